// File: doc/BRIEF.md
# Double-Buffered Synchronous Serial Port Datapath

This block moves fixed-length data words between a parallel host interface and two serial lines, one for each direction. Each direction has its own bit clock and frame-sync input. Both are oversampled in the system clock domain. A word starts on the bit-clock rising edge where frame sync is seen high. Its bits follow MSB first, one on each of the next rising edges.

On the transmit side, the host writes into a holding register. At frame start, the holding register is loaded into a shift register, and the host can then write the next word while the current one shifts out. If the holding register is empty at frame start, the previous word is sent again and an underrun pulse is raised.

On the receive side, a completed word goes from the shift register to a buffer register. From there it moves to the host-readable data register whenever that register is empty. Two finished words can therefore wait while a third is arriving. A word that completes while both registers are full is dropped, and an overrun pulse is raised.

Top module: `sport_dp`

## Requirements
- R1: `wl_sel_i` selects the word length for both directions: code 0 is 8 bits, 1 is 12, 2 is 16, 3 is 20, 4 is 24, and 5, 6 and 7 are 32. The transmitter sends bits [len-1:0] of the word. The receiver returns the word right-justified, with upper bits zero.
- R2: `tx_d_o` carries the word MSB first. The first bit is driven after the bit-clock rising edge that follows the edge where `tx_fs_i` is seen high, and one bit follows per rising edge. Outside a word `tx_d_o` is 0.
- R3: `tx_ready_o` is high exactly when the holding register is empty. It returns high at frame start, so the next word can be written while the current one shifts.
- R4: A write (`tx_we_i`) while `tx_ready_o` is low is ignored and does not change the word that is sent.
- R5: If a frame starts while the holding register is empty, `tx_urun_o` pulses for one clock and the previously sent word is transmitted again. After reset, the previous word is zero.
- R6: `rx_d_i` is sampled on the rising bit-clock edges after the edge where `rx_fs_i` is high, MSB first.
- R7: `rx_full_o` is high while the data register holds unread data, and a one-cycle `rx_re_i` pulse consumes it. A buffered word moves into the data register once it is empty, so two completed words are kept in arrival order.
- R8: A word that completes while both the buffer and the data register are full is discarded. `rx_ovr_o` pulses for one clock and the stored words are unchanged.
- R9: A read while `rx_full_o` is low has no effect: `rx_rdata_o` keeps its value. While the data register is full and not read, its value is stable.
- R10: After reset, `tx_ready_o` is 1, and `rx_full_o`, `tx_d_o`, `tx_urun_o` and `rx_ovr_o` are 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| wl_sel_i | input | 3 | Word length code |
| tx_bclk_i | input | 1 | Transmit bit clock |
| tx_fs_i | input | 1 | Transmit frame sync |
| tx_d_o | output | 1 | Serial transmit data |
| tx_wdata_i | input | 32 | Host word to send |
| tx_we_i | input | 1 | Host write strobe |
| tx_ready_o | output | 1 | Holding register empty |
| tx_urun_o | output | 1 | Underrun pulse |
| rx_bclk_i | input | 1 | Receive bit clock |
| rx_fs_i | input | 1 | Receive frame sync |
| rx_d_i | input | 1 | Serial receive data |
| rx_rdata_o | output | 32 | Received word |
| rx_re_i | input | 1 | Host read strobe |
| rx_full_o | output | 1 | Unread word present |
| rx_ovr_o | output | 1 | Overrun pulse |

## Verification
Errors in the holding-register state show up at the next frame start. A wrong empty flag either sends a stale word or loses a written one, and in both cases the word seen on `tx_d_o` and the underrun count disagree within one frame. Errors in receive hand-off or occupancy show up on the next read: a missing, repeated or reordered word, or an overrun counted when a slot was free. A bit-alignment or length error corrupts the first frame's data. The bench therefore compares every transmitted frame, every read and both event counts against a model of two-entry receive storage and single-entry transmit storage.

// File: rtl/sport_pkg.sv
package sport_pkg;
  localparam int unsigned MAX_W = 32;
  localparam int unsigned CNT_W = $clog2(MAX_W + 1);

  function automatic logic [CNT_W-1:0] wl_bits(input logic [2:0] sel);
    case (sel)
      3'd0: wl_bits = CNT_W'(8);
      3'd1: wl_bits = CNT_W'(12);
      3'd2: wl_bits = CNT_W'(16);
      3'd3: wl_bits = CNT_W'(20);
      3'd4: wl_bits = CNT_W'(24);
      default: wl_bits = CNT_W'(32);
    endcase
  endfunction
endpackage

// File: rtl/sport_sync.sv
module sport_sync #(
  parameter int unsigned W      = 1,
  parameter int unsigned STAGES = 2
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);
  logic [W-1:0] st_q [STAGES];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int i = 0; i < STAGES; i++) st_q[i] <= '0;
    end else begin
      st_q[0] <= d_i;
      for (int i = 1; i < STAGES; i++) st_q[i] <= st_q[i-1];
    end
  end

  assign q_o = st_q[STAGES-1];
endmodule

// File: rtl/sport_tx.sv
module sport_tx #(
  parameter int unsigned DW     = sport_pkg::MAX_W,
  parameter int unsigned SYNC_N = 2,
  localparam int unsigned CW    = $clog2(DW + 1)
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic [CW-1:0] wl_i,
  input  logic          bclk_i,
  input  logic          fs_i,
  output logic          d_o,
  input  logic [DW-1:0] wdata_i,
  input  logic          we_i,
  output logic          ready_o,
  output logic          urun_o
);
  logic          bclk_s, fs_s, bclk_q, rise;
  logic [DW-1:0] hold_q, last_q, sh_q, load_word;
  logic          hold_v_q, busy_q;
  logic [CW-1:0] cnt_q;

  sport_sync #(.W(2), .STAGES(SYNC_N)) u_sync (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .d_i   ({bclk_i, fs_i}),
    .q_o   ({bclk_s, fs_s})
  );

  assign rise      = bclk_s & ~bclk_q;
  assign load_word = hold_v_q ? hold_q : last_q;
  assign ready_o   = ~hold_v_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      bclk_q   <= 1'b0;
      hold_q   <= '0;
      hold_v_q <= 1'b0;
      last_q   <= '0;
      sh_q     <= '0;
      cnt_q    <= '0;
      busy_q   <= 1'b0;
      d_o      <= 1'b0;
      urun_o   <= 1'b0;
    end else begin
      bclk_q <= bclk_s;
      urun_o <= 1'b0;
      // holding register only accepts when empty
      if (we_i && !hold_v_q) begin
        hold_q   <= wdata_i;
        hold_v_q <= 1'b1;
      end
      if (rise) begin
        if (fs_s) begin
          last_q <= load_word;
          sh_q   <= load_word << (CW'(DW) - wl_i);
          cnt_q  <= wl_i;
          busy_q <= 1'b1;
          d_o    <= 1'b0;
          urun_o <= ~hold_v_q;
          if (hold_v_q) hold_v_q <= 1'b0;
        end else if (busy_q) begin
          d_o    <= sh_q[DW-1];
          sh_q   <= sh_q << 1;
          cnt_q  <= cnt_q - 1'b1;
          busy_q <= (cnt_q != CW'(1));
        end else begin
          d_o <= 1'b0;
        end
      end
    end
  end
endmodule

// File: rtl/sport_rx.sv
module sport_rx #(
  parameter int unsigned DW     = sport_pkg::MAX_W,
  parameter int unsigned SYNC_N = 2,
  localparam int unsigned CW    = $clog2(DW + 1)
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic [CW-1:0] wl_i,
  input  logic          bclk_i,
  input  logic          fs_i,
  input  logic          d_i,
  output logic [DW-1:0] rdata_o,
  input  logic          re_i,
  output logic          full_o,
  output logic          ovr_o
);
  logic          bclk_s, fs_s, d_s, bclk_q, rise, done, drr_free;
  logic [DW-1:0] sh_q, rbr_q, drr_q, new_word;
  logic          rbr_v_q, drr_v_q, busy_q;
  logic [CW-1:0] cnt_q;

  sport_sync #(.W(3), .STAGES(SYNC_N)) u_sync (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .d_i   ({bclk_i, fs_i, d_i}),
    .q_o   ({bclk_s, fs_s, d_s})
  );

  assign rise     = bclk_s & ~bclk_q;
  assign new_word = {sh_q[DW-2:0], d_s};
  assign done     = rise & ~fs_s & busy_q & (cnt_q == CW'(1));
  assign drr_free = ~drr_v_q | re_i;
  assign rdata_o  = drr_q;
  assign full_o   = drr_v_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      bclk_q  <= 1'b0;
      sh_q    <= '0;
      cnt_q   <= '0;
      busy_q  <= 1'b0;
      rbr_q   <= '0;
      rbr_v_q <= 1'b0;
      drr_q   <= '0;
      drr_v_q <= 1'b0;
      ovr_o   <= 1'b0;
    end else begin
      bclk_q <= bclk_s;
      ovr_o  <= 1'b0;
      if (re_i && drr_v_q) drr_v_q <= 1'b0;
      // buffer moves only into an empty (or just-read) data register
      if (drr_free && rbr_v_q) begin
        drr_q   <= rbr_q;
        drr_v_q <= 1'b1;
        rbr_v_q <= 1'b0;
      end
      if (done) begin
        if (!rbr_v_q || drr_free) begin
          rbr_q   <= new_word;
          rbr_v_q <= 1'b1;
        end else begin
          ovr_o <= 1'b1;
        end
      end
      if (rise) begin
        if (fs_s) begin
          sh_q   <= '0;
          cnt_q  <= wl_i;
          busy_q <= 1'b1;
        end else if (busy_q) begin
          sh_q   <= new_word;
          cnt_q  <= cnt_q - 1'b1;
          busy_q <= (cnt_q != CW'(1));
        end
      end
    end
  end
endmodule

// File: rtl/sport_dp.sv
module sport_dp #(
  parameter int unsigned DW     = sport_pkg::MAX_W,
  parameter int unsigned SYNC_N = 2
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic [2:0]    wl_sel_i,
  input  logic          tx_bclk_i,
  input  logic          tx_fs_i,
  output logic          tx_d_o,
  input  logic [DW-1:0] tx_wdata_i,
  input  logic          tx_we_i,
  output logic          tx_ready_o,
  output logic          tx_urun_o,
  input  logic          rx_bclk_i,
  input  logic          rx_fs_i,
  input  logic          rx_d_i,
  output logic [DW-1:0] rx_rdata_o,
  input  logic          rx_re_i,
  output logic          rx_full_o,
  output logic          rx_ovr_o
);
  localparam int unsigned CW = $clog2(DW + 1);

  logic [CW-1:0] wl;
  assign wl = CW'(sport_pkg::wl_bits(wl_sel_i));

  sport_tx #(.DW(DW), .SYNC_N(SYNC_N)) u_tx (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .wl_i   (wl),
    .bclk_i (tx_bclk_i),
    .fs_i   (tx_fs_i),
    .d_o    (tx_d_o),
    .wdata_i(tx_wdata_i),
    .we_i   (tx_we_i),
    .ready_o(tx_ready_o),
    .urun_o (tx_urun_o)
  );

  sport_rx #(.DW(DW), .SYNC_N(SYNC_N)) u_rx (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .wl_i   (wl),
    .bclk_i (rx_bclk_i),
    .fs_i   (rx_fs_i),
    .d_i    (rx_d_i),
    .rdata_o(rx_rdata_o),
    .re_i   (rx_re_i),
    .full_o (rx_full_o),
    .ovr_o  (rx_ovr_o)
  );
endmodule

// File: rtl/sport_dp_chk.sv
module sport_dp_chk #(
  parameter int unsigned DW = 32
) (
  input logic          clk_i,
  input logic          rst_ni,
  input logic          tx_we_i,
  input logic          tx_ready_o,
  input logic          tx_urun_o,
  input logic [DW-1:0] rx_rdata_o,
  input logic          rx_re_i,
  input logic          rx_full_o,
  input logic          rx_ovr_o
);
  assert_ready_fall_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(tx_ready_o) |-> $past(tx_we_i));

  assert_urun_empty_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tx_urun_o |-> $past(tx_ready_o));

  assert_ovr_full_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rx_ovr_o |-> ($past(rx_full_o) && !$past(rx_re_i)));

  assert_full_hold_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rx_full_o && !rx_re_i) |=> (rx_full_o && $stable(rx_rdata_o)));

  assert_full_fall_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(rx_full_o) |-> $past(rx_re_i));
endmodule

bind sport_dp sport_dp_chk #(.DW(DW)) chk_i (
  .clk_i     (clk_i),
  .rst_ni    (rst_ni),
  .tx_we_i   (tx_we_i),
  .tx_ready_o(tx_ready_o),
  .tx_urun_o (tx_urun_o),
  .rx_rdata_o(rx_rdata_o),
  .rx_re_i   (rx_re_i),
  .rx_full_o (rx_full_o),
  .rx_ovr_o  (rx_ovr_o)
);

// File: tb/sport_dp_tb_top.sv
module sport_dp_tb_top;
  localparam int H = 4;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [2:0]  wl_sel = 3'd0;
  logic        tx_bclk = 1'b0, tx_fs = 1'b0, tx_d;
  logic [31:0] tx_wdata = '0;
  logic        tx_we = 1'b0, tx_ready, tx_urun;
  logic        rx_bclk = 1'b0, rx_fs = 1'b0, rx_d = 1'b0;
  logic [31:0] rx_rdata;
  logic        rx_re = 1'b0, rx_full, rx_ovr;

  int checks = 0, errors = 0;
  int urun_seen = 0, ovr_seen = 0, urun_exp = 0, ovr_exp = 0;
  bit done = 0;

  // bench models
  logic [31:0] m_hold = '0, m_last = '0;
  bit          m_pend = 0;
  logic [31:0] m_q [2];
  int          m_n = 0;
  logic [31:0] m_lastrd = '0;

  always #2.5 clk = ~clk;

  sport_dp dut_i (
    .clk_i(clk), .rst_ni(rst_n), .wl_sel_i(wl_sel),
    .tx_bclk_i(tx_bclk), .tx_fs_i(tx_fs), .tx_d_o(tx_d),
    .tx_wdata_i(tx_wdata), .tx_we_i(tx_we), .tx_ready_o(tx_ready), .tx_urun_o(tx_urun),
    .rx_bclk_i(rx_bclk), .rx_fs_i(rx_fs), .rx_d_i(rx_d),
    .rx_rdata_o(rx_rdata), .rx_re_i(rx_re), .rx_full_o(rx_full), .rx_ovr_o(rx_ovr)
  );

  always @(posedge clk) begin
    if (rst_n && tx_urun) urun_seen++;
    if (rst_n && rx_ovr) ovr_seen++;
  end

  function automatic int wl_of(input logic [2:0] c);
    case (c)
      3'd0: return 8;  3'd1: return 12; 3'd2: return 16;
      3'd3: return 20; 3'd4: return 24; default: return 32;
    endcase
  endfunction

  function automatic logic [31:0] mask_of(input int wl);
    return (wl >= 32) ? 32'hFFFF_FFFF : ((32'd1 << wl) - 32'd1);
  endfunction

  task automatic check(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic bit_cyc(input bit tx_side, input logic fs, input logic d);
    if (tx_side) begin tx_fs = fs; tx_bclk = 1'b1; end
    else begin rx_fs = fs; rx_d = d; rx_bclk = 1'b1; end
    repeat (H) @(negedge clk);
    if (tx_side) tx_bclk = 1'b0; else rx_bclk = 1'b0;
    repeat (H) @(negedge clk);
  endtask

  task automatic tx_write(input logic [31:0] w);
    check(tx_ready == !m_pend, "R3", 32'(tx_ready), 32'(!m_pend));
    if (!m_pend) begin m_hold = w; m_pend = 1; end
    tx_wdata = w; tx_we = 1'b1;
    @(negedge clk);
    tx_we = 1'b0;
  endtask

  // mid_at < 0: no write during the frame
  task automatic tx_frame(input int mid_at, input logic [31:0] mid_w);
    int wl = wl_of(wl_sel);
    logic [31:0] exp, got;
    if (m_pend) begin exp = m_hold; m_pend = 0; end
    else begin exp = m_last; urun_exp++; end
    m_last = exp;
    got = '0;
    bit_cyc(1, 1'b1, 1'b0);
    check(tx_ready == 1'b1, "R3 ready after load", 32'(tx_ready), 32'd1);
    for (int i = wl - 1; i >= 0; i--) begin
      bit_cyc(1, 1'b0, 1'b0);
      got = {got[30:0], tx_d};
      if (i == mid_at) tx_write(mid_w);
    end
    check(got == (exp & mask_of(wl)), "R1 R2 R5 tx word", got, exp & mask_of(wl));
    bit_cyc(1, 1'b0, 1'b0);
    check(tx_d == 1'b0, "R2 idle low", 32'(tx_d), 32'd0);
  endtask

  task automatic rx_frame(input logic [31:0] w);
    int wl = wl_of(wl_sel);
    bit_cyc(0, 1'b1, 1'b0);
    for (int i = wl - 1; i >= 0; i--) bit_cyc(0, 1'b0, w[i]);
    repeat (3) @(negedge clk);
    if (m_n < 2) begin m_q[m_n] = w & mask_of(wl); m_n++; end
    else ovr_exp++;
  endtask

  task automatic rx_read();
    check(rx_full == (m_n > 0), "R7 full flag", 32'(rx_full), 32'(m_n > 0));
    if (m_n > 0) begin
      check(rx_rdata == m_q[0], "R6 R7 read data", rx_rdata, m_q[0]);
      m_lastrd = m_q[0];
      m_q[0] = m_q[1];
      m_n--;
    end else begin
      check(rx_rdata == m_lastrd, "R9 empty read", rx_rdata, m_lastrd);
    end
    rx_re = 1'b1;
    @(negedge clk);
    rx_re = 1'b0;
    repeat (3) @(negedge clk);
    check(rx_full == (m_n > 0), "R7 full after read", 32'(rx_full), 32'(m_n > 0));
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd1234));
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    // R10 reset state
    check(tx_ready == 1'b1, "R10 ready", 32'(tx_ready), 32'd1);
    check(rx_full == 1'b0, "R10 full", 32'(rx_full), 32'd0);
    check(tx_d == 1'b0, "R10 tx_d", 32'(tx_d), 32'd0);
    check(urun_seen == 0 && ovr_seen == 0, "R10 pulses", 32'(urun_seen + ovr_seen), 32'd0);

    // R3/R4/R5 directed, 16-bit words
    wl_sel = 3'd2;
    tx_write(32'hDEAD_A5C3);
    tx_write(32'h0000_1111);            // R4: ignored
    tx_frame(5, 32'h0000_7E81);         // R3: write mid-frame
    check(tx_ready == 1'b0, "R3 holds next", 32'(tx_ready), 32'd0);
    tx_frame(-1, '0);
    tx_frame(-1, '0);                   // R5: repeat + underrun
    check(urun_seen == urun_exp, "R5 underrun count", 32'(urun_seen), 32'(urun_exp));

    // R1 every code, both directions
    for (int c = 0; c < 8; c++) begin
      logic [31:0] w = $urandom;
      wl_sel = 3'(c);
      tx_write(w);
      tx_frame(-1, '0);
      rx_frame(~w);
      rx_read();
    end

    // R7/R8/R9 directed, 8-bit words
    wl_sel = 3'd0;
    rx_frame(32'h0000_00A1);
    rx_frame(32'h0000_00B2);
    rx_frame(32'h0000_00C3);            // R8: dropped
    check(ovr_seen == ovr_exp, "R8 overrun count", 32'(ovr_seen), 32'(ovr_exp));
    rx_read();
    rx_read();
    rx_read();                          // R9: empty read
    rx_read();

    // random mix
    for (int it = 0; it < 40; it++) begin
      wl_sel = 3'($urandom_range(0, 7));
      if ($urandom_range(0, 3) != 0) tx_write($urandom);
      tx_frame(($urandom_range(0, 1) != 0) ? 2 : -1, $urandom);
      rx_frame($urandom);
      if ($urandom_range(0, 2) != 0) rx_read();
    end
    while (m_n > 0) rx_read();

    check(urun_seen == urun_exp, "R5 total underruns", 32'(urun_seen), 32'(urun_exp));
    check(ovr_seen == ovr_exp, "R8 total overruns", 32'(ovr_seen), 32'(ovr_exp));
    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule